// File: doc/BRIEF.md
# External Memory Bus Controller

This controller sits between an 8-bit microcontroller core and a multiplexed external memory bus with a 16-bit address space. The core hands it one access at a time: a code fetch, a data read or a data write. For a code fetch, the controller first checks whether the access can stay on chip. When the internal-code pin is high, addresses below the internal code size (4 KB by default) go to internal program memory. Every other code fetch, and every data access, goes out as an external bus cycle.

An external cycle runs a fixed sequence of phases:
- The low address byte is placed on the shared byte port while the latch strobe is high.
- The low address byte stays on the port for one cycle after the strobe falls, so that an external latch can capture it.
- For a read, the port is released. For a write, the data byte is driven onto it.
- The code strobe, read strobe or write strobe is then held low for a set number of cycles.
- The high address byte is on its own port for the whole cycle.

The core side uses valid/ready streams:
- **Requests.** A request is taken only while `req_ready` is high. That happens only when no access is in progress, so the ready signal is the back-pressure.
- **Responses.** Each access ends with one response beat. It is held, with stable data, until the core raises `rsp_ready`, and no new request is taken before that.

Top module: `xbus_ctrl`

## Requirements
- R1: During and right after reset, req_ready is 1, rsp_valid is 0, ale is 0, psen_n, rd_n and wr_n are 1, and ad_oe is 0.
- R2: req_kind encodes 2'b00 as code fetch, 2'b01 as data read and 2'b10 as data write. A code fetch with use_int_rom=1 and an address below 0x1000 is served internally: int_rd_en pulses once, the response carries the int_rdata returned one cycle later, and ale and psen_n stay inactive.
- R3: A code fetch with use_int_rom=1 and an address of 0x1000 or above is run on the external bus.
- R4: With use_int_rom=0, every code fetch, including address 0x0000, is run on the external bus, and int_rd_en stays 0.
- R5: An external cycle holds ale high for ALE_CYC cycles (default 1) while ad_oe is 1 and ad_out carries address bits 7..0. The address stays on ad_out through the cycle in which ale falls, so a latch closing on that fall captures the low byte.
- R6: hi_addr equals address bits 15..8 whenever ale or any strobe is active.
- R7: A code fetch drives psen_n low, and a data read drives rd_n low, for STRB_CYC cycles (default 2). The other two strobes stay high, and at most one strobe is low at any time.
- R8: During external reads ad_oe is 0 while psen_n or rd_n is low. The response carries ad_in as sampled on the last strobe cycle.
- R9: A data write drives wr_n low for STRB_CYC cycles. ad_oe is 1 with ad_out equal to the write byte while wr_n is low and for one cycle after it rises. The write response carries 0.
- R10: req_ready is 0 from the accepting edge until the response has been taken.
- R11: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data is unchanged.
- R12: Data reads and writes always use the external bus, regardless of use_int_rom or the internal code boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| use_int_rom | input | 1 | 1: code below the internal size is served on chip |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_kind | input | 2 | 00 code fetch, 01 data read, 10 data write |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_data | output | DATA_W | Read byte (0 for writes) |
| int_rd_en | output | 1 | Internal code memory read enable |
| int_addr | output | INT_AW | Internal code memory address |
| int_rdata | input | DATA_W | Internal code byte, one cycle after enable |
| ad_out | output | DATA_W | Shared port output: low address, then write data |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | DATA_W | Shared port input |
| hi_addr | output | ADDR_W-DATA_W | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The response-hold property (R11) assumes that the core does not reassert reset in the middle of a response. The bench only applies reset once, before any traffic.

The assertions on strobes and the shared port do not depend on any input behaviour. They do assume that the core's req_kind never carries 2'b11, and the bench issues only the three defined encodings.

The bench drives requests and rsp_ready on falling edges and keeps them stable across the sampling edge. It models the external latch and memories behaviourally. Internal code data is returned exactly one cycle after int_rd_en, as R2 presumes.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
  // Access kinds presented by the core
  localparam logic [1:0] K_CODE = 2'b00;
  localparam logic [1:0] K_DRD  = 2'b01;
  localparam logic [1:0] K_DWR  = 2'b10;

  // Phases of one access
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT,
    ST_INTCAP,
    ST_ADDR,
    ST_HOLD,
    ST_STRB,
    ST_END,
    ST_RSP
  } xstate_t;
endpackage

// File: rtl/xbus_route.sv
`timescale 1ns/1ps
module xbus_route
  import xbus_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int INT_CODE_BYTES = 4096
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              use_int_rom,
  output logic              go_ext
);
  localparam logic [ADDR_W-1:0] INT_LIMIT = ADDR_W'(INT_CODE_BYTES);

  logic below_limit;
  logic is_code;

  assign below_limit = (addr < INT_LIMIT);
  assign is_code     = (kind == K_CODE);
  // Only code fetches under the boundary with the pin high stay on chip
  assign go_ext      = !(is_code && use_int_rom && below_limit);
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int ALE_CYC  = 1,
  parameter int STRB_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              go_ext,
  input  logic              rsp_ready,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [DATA_W-1:0] int_rdata,
  output xstate_t           st,
  output logic [1:0]        kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rsp_data,
  output logic              req_ready,
  output logic              rsp_valid
);
  localparam int MAXC = (ALE_CYC > STRB_CYC) ? ALE_CYC : STRB_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ALE_LAST  = CW'(ALE_CYC - 1);
  localparam logic [CW-1:0] STRB_LAST = CW'(STRB_CYC - 1);

  logic [CW-1:0] cnt;

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RSP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      kind_q   <= K_CODE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rsp_data <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            kind_q  <= req_kind;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            cnt     <= ALE_LAST;
            st      <= go_ext ? ST_ADDR : ST_INT;
          end
        end
        ST_INT:    st <= ST_INTCAP;
        ST_INTCAP: begin
          rsp_data <= int_rdata;
          st       <= ST_RSP;
        end
        ST_ADDR: begin
          if (cnt == '0) st <= ST_HOLD;
          else           cnt <= cnt - 1'b1;
        end
        ST_HOLD: begin
          cnt <= STRB_LAST;
          st  <= ST_STRB;
        end
        ST_STRB: begin
          if (cnt == '0) begin
            // Sample on the last strobe cycle; writes answer with zero
            rsp_data <= kind_q[1] ? '0 : ad_in;
            st       <= ST_END;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_END: st <= ST_RSP;
        ST_RSP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_pins.sv
`timescale 1ns/1ps
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int INT_AW = 12
) (
  input  xstate_t                  st,
  input  logic [1:0]               kind_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     int_rd_en,
  output logic [INT_AW-1:0]        int_addr
);
  logic is_wr;
  logic is_code;

  assign is_wr    = kind_q[1];
  assign is_code  = (kind_q == K_CODE);
  assign hi_addr  = addr_q[ADDR_W-1:DATA_W];
  assign int_addr = addr_q[INT_AW-1:0];

  always_comb begin
    ad_out    = '0;
    ad_oe     = 1'b0;
    ale       = 1'b0;
    psen_n    = 1'b1;
    rd_n      = 1'b1;
    wr_n      = 1'b1;
    int_rd_en = 1'b0;
    unique case (st)
      ST_INT: int_rd_en = 1'b1;
      ST_ADDR: begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = addr_q[DATA_W-1:0];
      end
      ST_HOLD: begin
        ad_oe  = 1'b1;
        ad_out = addr_q[DATA_W-1:0];
      end
      ST_STRB: begin
        if (is_code) begin
          psen_n = 1'b0;
        end else if (is_wr) begin
          wr_n   = 1'b0;
          ad_oe  = 1'b1;
          ad_out = wdata_q;
        end else begin
          rd_n = 1'b0;
        end
      end
      ST_END: begin
        if (is_wr) begin
          ad_oe  = 1'b1;
          ad_out = wdata_q;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int INT_CODE_BYTES = 4096,
  parameter int ALE_CYC        = 1,
  parameter int STRB_CYC       = 2,
  localparam int INT_AW        = $clog2(INT_CODE_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     use_int_rom,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     int_rd_en,
  output logic [INT_AW-1:0]        int_addr,
  input  logic [DATA_W-1:0]        int_rdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n
);
  xstate_t           st;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              go_ext;

  xbus_route #(.ADDR_W(ADDR_W), .INT_CODE_BYTES(INT_CODE_BYTES)) u_route (
    .kind(req_kind), .addr(req_addr), .use_int_rom(use_int_rom), .go_ext(go_ext)
  );

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALE_CYC(ALE_CYC), .STRB_CYC(STRB_CYC)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .go_ext(go_ext),
    .rsp_ready(rsp_ready), .ad_in(ad_in), .int_rdata(int_rdata),
    .st(st), .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .rsp_data(rsp_data), .req_ready(req_ready), .rsp_valid(rsp_valid)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_AW(INT_AW)) u_pins (
    .st(st), .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .int_rd_en(int_rd_en), .int_addr(int_addr)
  );
endmodule

// File: rtl/xbus_chk.sv
`timescale 1ns/1ps
module xbus_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [DATA_W-1:0]        rsp_data,
  input logic                     int_rd_en,
  input logic                     ad_oe,
  input logic [ADDR_W-DATA_W-1:0] hi_addr,
  input logic                     ale,
  input logic                     psen_n,
  input logic                     rd_n,
  input logic                     wr_n
);
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  p_port_free_on_read_r8: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !ad_oe);

  p_write_drives_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);

  p_ale_drives_r5: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && psen_n && rd_n && wr_n));

  p_hi_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n || !wr_n) |-> (hi_addr == $past(hi_addr)));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  p_int_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    int_rd_en |-> (!ale && psen_n && rd_n && wr_n));
endmodule

bind xbus_ctrl xbus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .int_rd_en(int_rd_en),
  .ad_oe(ad_oe), .hi_addr(hi_addr), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/tb_xbus_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_ctrl;
  localparam int STRB = 2;
  localparam int ALEC = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        use_int_rom = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        int_rd_en;
  logic [11:0] int_addr;
  logic [7:0]  int_rdata = '0;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  hi_addr;
  logic        ale, psen_n, rd_n, wr_n;

  always #5 clk = ~clk;

  xbus_ctrl dut (
    .clk(clk), .rst(rst), .use_int_rom(use_int_rom),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .int_rd_en(int_rd_en), .int_addr(int_addr), .int_rdata(int_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  // Behavioural external world: latch, code memory, small data memory
  logic [7:0] lat = '0;
  logic [7:0] dmem [256];

  function automatic logic [7:0] code_fn(input logic [15:0] a);
    return a[7:0] + a[15:8];
  endfunction

  always @(negedge ale) lat <= ad_out;
  assign ad_in = !psen_n ? code_fn({hi_addr, lat}) :
                 !rd_n   ? dmem[lat ^ hi_addr] : 8'hFF;
  always @(posedge wr_n) if (!rst) dmem[lat ^ hi_addr] <= ad_out;
  always @(posedge clk) if (int_rd_en) int_rdata <= int_addr[7:0] ^ 8'h5A;

  // Cumulative pin monitor
  int c_ale = 0, c_psen = 0, c_rd = 0, c_wr = 0, c_int = 0;
  int c_oe_bad = 0, c_ale_bad = 0, c_hi_bad = 0, c_wr_bad = 0;
  logic [7:0] exp_lo = '0, exp_hi = '0, exp_wd = '0;

  always @(negedge clk) if (!rst) begin
    c_ale  <= c_ale + int'(ale);
    c_psen <= c_psen + int'(!psen_n);
    c_rd   <= c_rd + int'(!rd_n);
    c_wr   <= c_wr + int'(!wr_n);
    c_int  <= c_int + int'(int_rd_en);
    if ((!psen_n || !rd_n) && ad_oe) c_oe_bad <= c_oe_bad + 1;
    if (ale && (!ad_oe || ad_out != exp_lo)) c_ale_bad <= c_ale_bad + 1;
    if ((ale || !psen_n || !rd_n || !wr_n) && hi_addr != exp_hi) c_hi_bad <= c_hi_bad + 1;
    if (!wr_n && (!ad_oe || ad_out != exp_wd)) c_wr_bad <= c_wr_bad + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int d_ale, d_psen, d_rd, d_wr, d_int, d_oe, d_albad, d_hi, d_wrbad;
  logic busy_seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [1:0] k, input logic [15:0] a,
                     input logic [7:0] wd, input bit hold_rsp, output logic [7:0] d);
    int s_ale, s_psen, s_rd, s_wr, s_int, s_oe, s_albad, s_hi, s_wrbad;
    int guard;
    @(negedge clk);
    s_ale = c_ale; s_psen = c_psen; s_rd = c_rd; s_wr = c_wr; s_int = c_int;
    s_oe = c_oe_bad; s_albad = c_ale_bad; s_hi = c_hi_bad; s_wrbad = c_wr_bad;
    exp_lo = a[7:0]; exp_hi = a[15:8]; exp_wd = wd;
    req_kind = k; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    rsp_ready = !hold_rsp;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = req_ready;
    guard = 0;
    while (!rsp_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 100) chk("R10 response timeout", 32'd1, 32'd0);
    d = rsp_data;
    if (!hold_rsp) @(negedge clk);
    d_ale = c_ale - s_ale; d_psen = c_psen - s_psen; d_rd = c_rd - s_rd;
    d_wr = c_wr - s_wr; d_int = c_int - s_int; d_oe = c_oe_bad - s_oe;
    d_albad = c_ale_bad - s_albad; d_hi = c_hi_bad - s_hi; d_wrbad = c_wr_bad - s_wrbad;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 req_ready in reset", req_ready, 1);
    chk("R1 strobes in reset", {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 idle pins after reset", {req_ready, ale, psen_n, rd_n, wr_n, ad_oe}, 6'b101110);
  endtask

  task automatic t_code_internal();
    logic [7:0] d;
    use_int_rom = 1'b1;
    txn(2'b00, 16'h0123, 8'h00, 1'b0, d);
    chk("R2 internal data 0123", d, 8'h23 ^ 8'h5A);
    chk("R2 one internal read", d_int, 1);
    chk("R2 no ale/psen internal", d_ale + d_psen, 0);
    chk("R10 busy after accept", busy_seen, 0);
    txn(2'b00, 16'h0FFF, 8'h00, 1'b0, d);
    chk("R2 boundary 0FFF internal", d, 8'hFF ^ 8'h5A);
    chk("R2 boundary no bus", d_ale + d_psen + d_rd, 0);
  endtask

  task automatic t_code_external_high();
    logic [7:0] d;
    use_int_rom = 1'b1;
    txn(2'b00, 16'h1000, 8'h00, 1'b0, d);
    chk("R3 1000 external data", d, code_fn(16'h1000));
    chk("R3 no internal read", d_int, 0);
    chk("R7 psen cycles", d_psen, STRB);
    chk("R7 no rd/wr on code", d_rd + d_wr, 0);
    chk("R5 ale cycles", d_ale, ALEC);
    chk("R5 latched low byte", lat, 8'h00);
    txn(2'b00, 16'hABCD, 8'h00, 1'b0, d);
    chk("R8 sampled code byte", d, code_fn(16'hABCD));
    chk("R5 latch ABCD", lat, 8'hCD);
    chk("R5 ale drives address", d_albad, 0);
    chk("R6 hi byte steady", d_hi, 0);
    chk("R8 port released", d_oe, 0);
  endtask

  task automatic t_code_all_external();
    logic [7:0] d;
    use_int_rom = 1'b0;
    txn(2'b00, 16'h0000, 8'h00, 1'b0, d);
    chk("R4 0000 external data", d, code_fn(16'h0000));
    chk("R4 no internal read", d_int, 0);
    chk("R4 psen used", d_psen, STRB);
    txn(2'b00, 16'h0FFF, 8'h00, 1'b0, d);
    chk("R4 0FFF external", d, code_fn(16'h0FFF));
    use_int_rom = 1'b1;
  endtask

  task automatic t_data_write_read();
    logic [7:0] d;
    txn(2'b10, 16'h2345, 8'h9E, 1'b0, d);
    chk("R9 wr cycles", d_wr, STRB);
    chk("R9 no psen/rd on write", d_psen + d_rd, 0);
    chk("R9 write data driven", d_wrbad, 0);
    chk("R9 write response zero", d, 0);
    chk("R9 memory updated", dmem[8'h45 ^ 8'h23], 8'h9E);
    txn(2'b01, 16'h2345, 8'h00, 1'b0, d);
    chk("R8 read back", d, 8'h9E);
    chk("R7 rd cycles", d_rd, STRB);
    chk("R7 no psen on data read", d_psen + d_wr, 0);
    chk("R8 port released on rd", d_oe, 0);
    chk("R6 hi on data", d_hi, 0);
  endtask

  task automatic t_data_low_address();
    logic [7:0] d;
    use_int_rom = 1'b1;
    txn(2'b01, 16'h0100, 8'h00, 1'b0, d);
    chk("R12 data read low addr external", d, 8'h01 ^ 8'hC3);
    chk("R12 no internal read", d_int, 0);
    chk("R12 rd used", d_rd, STRB);
  endtask

  task automatic t_backpressure();
    logic [7:0] d;
    txn(2'b00, 16'h4321, 8'h00, 1'b1, d);
    chk("R11 first data", d, code_fn(16'h4321));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 valid held", rsp_valid, 1);
      chk("R11 data held", rsp_data, code_fn(16'h4321));
      chk("R10 not ready while pending", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", rsp_valid, 0);
    chk("R10 ready again", req_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = 8'(i) ^ 8'hC3;
    t_reset();
    t_code_internal();
    t_code_external_high();
    t_code_all_external();
    t_data_write_read();
    t_data_low_address();
    t_backpressure();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
    end
  end
endmodule